// File: doc/BRIEF.md
# Triple-Redundant State Machine with Spare-Slot Repair

This block runs a small state machine in triple modular redundancy. Four identical module slots exist, named A, B, C and D (slot numbers 0 to 3). Three of them are active at any time and one waits as a spare. Each slot holds its own state register, its own next-state logic and its own per-bit majority voter. The voter reads the matching bit from all three active slots, and the next-state logic works from that voted value. The voted state is the block output, so one wrong flip-flop in an active slot never reaches it.

Comparison logic watches the three active slots. When exactly one slot disagrees with the other two, that slot is recorded as failed on the following clock edge. The block then requests the active set that leaves the failed slot out. Physical reconfiguration sits outside the block. It is modelled by the `act_set_i` input, which the surrounding logic drives with the requested code.

A slot that joins the active set still holds a stale value. For its first active cycle it is left out of comparison, and at the end of that cycle it loads the next state computed from the vote. The machine therefore runs through a permanent flip-flop failure without restarting. It is exposed for at most three cycles: the fault cycle, the reconfiguration cycle and the load cycle.

Two next-state modes are provided:
- In state-machine mode a twisted-ring sequence advances on `adv_i`.
- In counter mode bit 0 inverts on every cycle.

Top module: `tmr_fsm_repair`

## Requirements
- R1: After reset `state_o` is 0, `cfg_req_o` is 0 (set ABC), and `fail_vld_o`, `degraded_o`, `no_spare_o` and `uncorr_o` are all 0.
- R2: With `mode_i`=0 and `adv_i`=1, each clock edge moves the voted state s to {s[W-2:0], ~s[W-1]}; for W=2 this gives 00, 01, 11, 10, 00. With `adv_i`=0 the state holds.
- R3: With `mode_i`=1, each clock edge inverts bit 0 of the voted state and clears all upper bits.
- R4: `state_o` is the per-bit majority of the three active slots. A stuck bit in any single active slot leaves the `state_o` sequence unchanged.
- R5: Suppose exactly one of the three compared slots disagrees and no failure has been recorded yet. On the next clock edge, `fail_vld_o` pulses for one cycle, `fail_slot_o` gives the slot number (0=A, 1=B, 2=C, 3=D), and `cfg_req_o` becomes the code that omits that slot. The set codes are: 0=ABC, 1=ABD, 2=ACD, 3=BCD, so code k omits slot 3-k.
- R6: The active set is the `act_set_i` code captured at each clock edge. A slot outside the active set keeps its register value.
- R7: A slot in its first active cycle is left out of comparison and loads the voted next state at the end of that cycle. `degraded_o` is high whenever one of these holds: the compared slots disagree, a recorded failed slot is still active, or a slot is in its first active cycle. After a single fault, with `act_set_i` following `cfg_req_o`, `degraded_o` is high for exactly three cycles.
- R8: A stuck bit in a slot outside the active set has no effect on `state_o`, `cfg_req_o` or any flag.
- R9: A failure in a further, not yet recorded slot after one failure is on record sets `no_spare_o`, which stays set until reset, and leaves `cfg_req_o` unchanged. A slot already on record never pulses `fail_vld_o` again.
- R10: When no compared slot agrees with another, `uncorr_o` is set on the next edge and stays set until reset, and `fail_vld_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = state-machine mode, 1 = counter mode |
| adv_i | input | 1 | Advance enable in state-machine mode |
| act_set_i | input | 2 | Active set code currently in effect (0=ABC, 1=ABD, 2=ACD, 3=BCD) |
| stuck_en_i | input | 4*W | Fault injection enable; bit slot*W+b forces bit b of that slot |
| stuck_val_i | input | 4*W | Value a forced bit takes |
| state_o | output | W | Voted state |
| cfg_req_o | output | 2 | Requested active set code |
| fail_vld_o | output | 1 | One-cycle pulse when a new failed slot is recorded |
| fail_slot_o | output | 2 | Slot number of the last recorded failure |
| degraded_o | output | 1 | The machine is not running full triple redundancy |
| no_spare_o | output | 1 | A failure was found after the spare had been used (stays set) |
| uncorr_o | output | 1 | A disagreement with no majority was seen (stays set) |

## Verification
A corrupted slot register inside the active set shows up as `degraded_o` in the same cycle. On the next edge it produces a `fail_vld_o` pulse, and `cfg_req_o` moves to the code that leaves that slot out. The state sequence itself must never change.

A replacement slot that fails to load the voted value would keep `degraded_o` high past the third cycle, or would raise a second failure report. A failure record that does not persist would show up as extra pulses or as a `cfg_req_o` change after the first repair. Either way the error is visible at the ports within one to four cycles of the fault.

// File: rtl/tmr_fsm_pkg.sv
package tmr_fsm_pkg;
  localparam int NSLOT = 4;

  typedef enum logic {
    MODE_FSM = 1'b0,
    MODE_CNT = 1'b1
  } mode_e;

  // set code k omits slot 3-k
  function automatic logic [NSLOT-1:0] set_members(input logic [1:0] code);
    logic [NSLOT-1:0] m;
    m = '1;
    m[2'd3 - code] = 1'b0;
    return m;
  endfunction

  function automatic logic [1:0] excl_code(input logic [1:0] slot);
    return 2'd3 - slot;
  endfunction

  // slot feeding comparison lane 0..2 under a set code
  function automatic logic [1:0] lane_slot(input logic [1:0] code, input logic [1:0] lane);
    logic [1:0] x;
    x = 2'd3 - code;
    return (lane < x) ? lane : lane + 2'd1;
  endfunction
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int W = 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] maj_o
);
  assign maj_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/tmr_slot.sv
module tmr_slot
  import tmr_fsm_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         mode_i,
  input  logic         adv_i,
  input  logic [W-1:0] lane_a_i,
  input  logic [W-1:0] lane_b_i,
  input  logic [W-1:0] lane_c_i,
  input  logic [W-1:0] stuck_en_i,
  input  logic [W-1:0] stuck_val_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] vote_o
);
  logic [W-1:0] st_q, nxt;

  tmr_voter #(.W(W)) u_voter (
    .a_i  (lane_a_i),
    .b_i  (lane_b_i),
    .c_i  (lane_c_i),
    .maj_o(vote_o)
  );

  always_comb begin
    if (mode_e'(mode_i) == MODE_CNT) nxt = {{(W-1){1'b0}}, ~vote_o[0]};
    else if (adv_i)                  nxt = {vote_o[W-2:0], ~vote_o[W-1]};
    else                             nxt = vote_o;
  end

  // out-of-set slots are unconfigured: hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= '0;
    else if (en_i) st_q <= nxt;
  end

  assign q_o = (st_q & ~stuck_en_i) | (stuck_val_i & stuck_en_i);

  p_hold_out_of_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(st_q));
endmodule

// File: rtl/tmr_fault_det.sv
module tmr_fault_det #(
  parameter int W = 2
) (
  input  logic [W-1:0] q0_i,
  input  logic [W-1:0] q1_i,
  input  logic [W-1:0] q2_i,
  input  logic [2:0]   fresh_i,
  output logic         diff_o,
  output logic         bad_vld_o,
  output logic [1:0]   bad_lane_o,
  output logic         unc_o
);
  logic e01, e02, e12;
  assign e01 = (q0_i == q1_i);
  assign e02 = (q0_i == q2_i);
  assign e12 = (q1_i == q2_i);

  always_comb begin
    diff_o     = 1'b0;
    bad_vld_o  = 1'b0;
    bad_lane_o = 2'd0;
    unc_o      = 1'b0;
    case (fresh_i)
      3'b000: begin
        diff_o = !(e01 && e02);
        if (diff_o) begin
          if (e12)      begin bad_vld_o = 1'b1; bad_lane_o = 2'd0; end
          else if (e02) begin bad_vld_o = 1'b1; bad_lane_o = 2'd1; end
          else if (e01) begin bad_vld_o = 1'b1; bad_lane_o = 2'd2; end
          else          unc_o = 1'b1;
        end
      end
      // one lane still loading: only two voices, no way to pick
      3'b001: begin diff_o = !e12; unc_o = !e12; end
      3'b010: begin diff_o = !e02; unc_o = !e02; end
      3'b100: begin diff_o = !e01; unc_o = !e01; end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_repair_ctl.sv
module tmr_repair_ctl
  import tmr_fsm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bad_vld_i,
  input  logic [1:0]       bad_slot_i,
  input  logic             unc_i,
  output logic [1:0]       req_o,
  output logic [NSLOT-1:0] failed_o,
  output logic             fail_vld_o,
  output logic [1:0]       fail_slot_o,
  output logic             no_spare_o,
  output logic             uncorr_o
);
  logic [1:0]       req_q, fail_slot_q;
  logic [NSLOT-1:0] failed_q, req_mask;
  logic             fail_vld_q, no_spare_q, uncorr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q       <= 2'd0;
      failed_q    <= '0;
      fail_vld_q  <= 1'b0;
      fail_slot_q <= 2'd0;
      no_spare_q  <= 1'b0;
      uncorr_q    <= 1'b0;
    end else begin
      fail_vld_q <= 1'b0;
      if (unc_i) uncorr_q <= 1'b1;
      if (bad_vld_i && !failed_q[bad_slot_i]) begin
        fail_vld_q            <= 1'b1;
        fail_slot_q           <= bad_slot_i;
        failed_q[bad_slot_i]  <= 1'b1;
        if (failed_q == '0) req_q      <= excl_code(bad_slot_i);
        else                no_spare_q <= 1'b1;
      end
    end
  end

  assign req_mask    = set_members(req_q);
  assign req_o       = req_q;
  assign failed_o    = failed_q;
  assign fail_vld_o  = fail_vld_q;
  assign fail_slot_o = fail_slot_q;
  assign no_spare_o  = no_spare_q;
  assign uncorr_o    = uncorr_q;

  p_req_omits_failed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_vld_q && !no_spare_q) |-> !req_mask[fail_slot_q]);
  p_req_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|failed_q) |=> $stable(req_q));
  p_no_spare_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_spare_q |=> no_spare_q);
  p_uncorr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_q |=> uncorr_q);
endmodule

// File: rtl/tmr_fsm_repair.sv
module tmr_fsm_repair
  import tmr_fsm_pkg::*;
#(
  parameter int W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             adv_i,
  input  logic [1:0]       act_set_i,
  input  logic [NSLOT*W-1:0] stuck_en_i,
  input  logic [NSLOT*W-1:0] stuck_val_i,
  output logic [W-1:0]     state_o,
  output logic [1:0]       cfg_req_o,
  output logic             fail_vld_o,
  output logic [1:0]       fail_slot_o,
  output logic             degraded_o,
  output logic             no_spare_o,
  output logic             uncorr_o
);
  localparam int NLANE = 3;

  logic [1:0]       act_q;
  logic [NSLOT-1:0] member, prev_q, fresh, failed;
  logic [W-1:0]     q_all    [NSLOT];
  logic [W-1:0]     vote_all [NSLOT];
  logic [W-1:0]     q_lane   [NLANE];
  logic [1:0]       lslot    [NLANE];
  logic [2:0]       lane_fresh;
  logic             diff, bad_vld, unc;
  logic [1:0]       bad_lane, bad_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 2'd0;
      prev_q <= set_members(2'd0);
    end else begin
      act_q  <= act_set_i;
      prev_q <= member;
    end
  end

  always_comb begin
    member = set_members(act_q);
    fresh  = member & ~prev_q;
    for (int i = 0; i < NLANE; i++) begin
      lslot[i]      = lane_slot(act_q, 2'(i));
      q_lane[i]     = q_all[lslot[i]];
      lane_fresh[i] = fresh[lslot[i]];
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    tmr_slot #(.W(W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (member[g]),
      .mode_i     (mode_i),
      .adv_i      (adv_i),
      .lane_a_i   (q_lane[0]),
      .lane_b_i   (q_lane[1]),
      .lane_c_i   (q_lane[2]),
      .stuck_en_i (stuck_en_i[g*W +: W]),
      .stuck_val_i(stuck_val_i[g*W +: W]),
      .q_o        (q_all[g]),
      .vote_o     (vote_all[g])
    );
  end

  tmr_fault_det #(.W(W)) u_det (
    .q0_i      (q_lane[0]),
    .q1_i      (q_lane[1]),
    .q2_i      (q_lane[2]),
    .fresh_i   (lane_fresh),
    .diff_o    (diff),
    .bad_vld_o (bad_vld),
    .bad_lane_o(bad_lane),
    .unc_o     (unc)
  );

  always_comb begin
    case (bad_lane)
      2'd1:    bad_slot = lslot[1];
      2'd2:    bad_slot = lslot[2];
      default: bad_slot = lslot[0];
    endcase
  end

  tmr_repair_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bad_vld_i  (bad_vld),
    .bad_slot_i (bad_slot),
    .unc_i      (unc),
    .req_o      (cfg_req_o),
    .failed_o   (failed),
    .fail_vld_o (fail_vld_o),
    .fail_slot_o(fail_slot_o),
    .no_spare_o (no_spare_o),
    .uncorr_o   (uncorr_o)
  );

  assign state_o    = vote_all[lslot[0]];
  assign degraded_o = diff | (|(failed & member)) | (|fresh);
endmodule

// File: tb/tmr_fsm_repair_tb.sv
`timescale 1ns/1ps
module tmr_fsm_repair_tb;
  localparam int W  = 2;
  localparam int NS = 4;

  logic clk = 1'b0, rst_ni = 1'b0, mode_i = 1'b0, adv_i = 1'b0;
  logic [1:0] act_set_i = 2'd0;
  logic [NS*W-1:0] stuck_en_i = '0, stuck_val_i = '0;
  logic [NS*W-1:0] pend_en = '0, pend_val = '0;
  logic [W-1:0] state_o;
  logic [1:0] cfg_req_o, fail_slot_o;
  logic fail_vld_o, degraded_o, no_spare_o, uncorr_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_tag = "R2";
  logic [W-1:0] ref_st = '0;
  logic [W-1:0] exp_q[$];

  always #2 clk = ~clk;

  tmr_fsm_repair #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .adv_i(adv_i),
    .act_set_i(act_set_i), .stuck_en_i(stuck_en_i), .stuck_val_i(stuck_val_i),
    .state_o(state_o), .cfg_req_o(cfg_req_o), .fail_vld_o(fail_vld_o),
    .fail_slot_o(fail_slot_o), .degraded_o(degraded_o),
    .no_spare_o(no_spare_o), .uncorr_o(uncorr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compare voted state after each edge
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      e = exp_q.pop_front();
      check({cur_tag, " R4 voted state"}, 32'(state_o), 32'(e));
    end
  end

  // driver: one cycle of stimulus, reconfiguration follows the request
  task automatic cyc(input logic adv, input logic md);
    logic [W-1:0] nxt;
    @(negedge clk);
    adv_i       = adv;
    mode_i      = md;
    act_set_i   = cfg_req_o;
    stuck_en_i  = pend_en;
    stuck_val_i = pend_val;
    if (md)       nxt = {1'b0, ~ref_st[0]};
    else if (adv) nxt = {ref_st[0], ~ref_st[1]};
    else          nxt = ref_st;
    exp_q.push_back(nxt);
    ref_st = nxt;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    exp_q.delete();
    rst_ni = 1'b0;
    adv_i = 1'b0; mode_i = 1'b0; act_set_i = 2'd0;
    pend_en = '0; pend_val = '0; stuck_en_i = '0; stuck_val_i = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    ref_st = '0;
    #1;
    check("R1 state", 32'(state_o), 0);
    check("R1 cfg_req", 32'(cfg_req_o), 0);
    check("R1 flags", {fail_vld_o, degraded_o, no_spare_o, uncorr_o}, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // state-machine mode, fault in slot A
    do_reset();
    cur_tag = "R2";
    repeat (3) cyc(1'b1, 1'b0);
    repeat (2) cyc(1'b0, 1'b0);
    cur_tag = "R5";
    pend_en[0*W+1]  = 1'b1;
    pend_val[0*W+1] = ~ref_st[1];
    cyc(1'b0, 1'b0);
    check("R7 degraded fault cycle", 32'(degraded_o), 1);
    check("R5 no pulse yet", 32'(fail_vld_o), 0);
    cyc(1'b0, 1'b0);
    check("R5 fail pulse", 32'(fail_vld_o), 1);
    check("R5 fail slot A", 32'(fail_slot_o), 0);
    check("R5 request BCD", 32'(cfg_req_o), 3);
    check("R7 degraded reconfig cycle", 32'(degraded_o), 1);
    cyc(1'b0, 1'b0);
    check("R6 degraded load cycle", 32'(degraded_o), 1);
    check("R7 stale spare not reported", 32'(fail_vld_o), 0);
    cyc(1'b1, 1'b0);
    check("R7 full TMR after three cycles", 32'(degraded_o), 0);
    check("R7 no uncorr from loading slot", 32'(uncorr_o), 0);
    check("R7 no spare flag", 32'(no_spare_o), 0);
    cur_tag = "R2";
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, 1'b0);
      check("R2 healthy after repair", 32'(degraded_o), 0);
    end
    // R8: excluded slot gets another stuck bit
    cur_tag = "R8";
    pend_en[0*W+0]  = 1'b1;
    pend_val[0*W+0] = 1'b1;
    cyc(1'b1, 1'b0);
    check("R8 excluded fault not degraded", 32'(degraded_o), 0);
    cyc(1'b1, 1'b0);
    check("R8 no pulse", 32'(fail_vld_o), 0);
    check("R8 request kept", 32'(cfg_req_o), 3);
    check("R8 no spare flag", 32'(no_spare_o), 0);
    // R9: second active slot fails, spare used up
    cur_tag = "R9";
    pend_en[1*W+0]  = 1'b1;
    pend_val[1*W+0] = ~ref_st[0];
    cyc(1'b1, 1'b0);
    check("R9 degraded on second fault", 32'(degraded_o), 1);
    cyc(1'b1, 1'b0);
    check("R9 pulse", 32'(fail_vld_o), 1);
    check("R9 slot B", 32'(fail_slot_o), 1);
    check("R9 no spare set", 32'(no_spare_o), 1);
    check("R9 request unchanged", 32'(cfg_req_o), 3);
    cyc(1'b1, 1'b0);
    check("R9 no spare sticky", 32'(no_spare_o), 1);
    check("R9 no repeat pulse", 32'(fail_vld_o), 0);
    check("R7 failed slot still active", 32'(degraded_o), 1);
    repeat (4) cyc(1'b1, 1'b0);

    // counter mode, fault in slot C
    do_reset();
    cur_tag = "R3";
    repeat (4) cyc(1'b0, 1'b1);
    pend_en[2*W+0]  = 1'b1;
    pend_val[2*W+0] = ~ref_st[0];
    cyc(1'b0, 1'b1);
    check("R3 degraded fault cycle", 32'(degraded_o), 1);
    cyc(1'b0, 1'b1);
    check("R5 slot C", 32'(fail_slot_o), 2);
    check("R5 request ABD", 32'(cfg_req_o), 1);
    cyc(1'b0, 1'b1);
    check("R7 counter load cycle", 32'(degraded_o), 1);
    cyc(1'b0, 1'b1);
    check("R7 counter full TMR", 32'(degraded_o), 0);
    repeat (4) cyc(1'b0, 1'b1);

    // R10: no majority among compared slots
    do_reset();
    cur_tag = "R10";
    pend_en[0*W+0]  = 1'b1; pend_val[0*W+0] = 1'b1;
    pend_en[1*W+1]  = 1'b1; pend_val[1*W+1] = 1'b1;
    cyc(1'b0, 1'b0);
    check("R10 degraded", 32'(degraded_o), 1);
    cyc(1'b0, 1'b0);
    check("R10 uncorr set", 32'(uncorr_o), 1);
    check("R10 no pulse", 32'(fail_vld_o), 0);
    check("R10 request kept", 32'(cfg_req_o), 0);
    cyc(1'b0, 1'b0);
    check("R10 uncorr sticky", 32'(uncorr_o), 1);

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule